// File: doc/BRIEF.md
# Interrupt Source Event Gate Bank

This block holds a bank of interrupt sources. Each source keeps a two-bit pending/queued state, a routing-level mask and a routing entry (target CPU, priority, event data word). Trigger events arrive on a per-source input. A source forwards an event only when its state and mask permit it. A trigger that arrives while an end-of-interrupt (EOI) is outstanding is coalesced into a single queued event. That queued event is sent again once the EOI arrives. Each source is fixed at build time as message-signalled (MSI, pulse triggers) or level-sensitive (LSI, level sampled every cycle).

Forwarded events leave on one valid/ready port carrying the source index and its routing tuple. The lowest-numbered requesting source wins. A granted event stays on the port until it is accepted, and the source's state changes only at acceptance. A configuration port writes one source's state, mask and routing fields in a single cycle and reads them back combinationally, together with the source's type.

Top module: `pq_src_bank`

## Requirements
- R1: After reset every source reads state 2'b01 (off), mask 1 and routing fields 0, and evt_valid_o is low.
- R2: An MSI trigger on an unmasked source in state 2'b00 (ready) presents exactly one event carrying that source's index, CPU, priority and data. The source moves to 2'b10 (pending) in the cycle the event is accepted.
- R3: An MSI trigger on a source in state 2'b10 moves it to 2'b11 (queued) and presents no event.
- R4: An MSI trigger on a source in state 2'b11 leaves it in 2'b11 and presents no event.
- R5: An EOI (eoi_valid_i with eoi_idx_i) to a source in state 2'b10 returns it to 2'b00 without presenting an event.
- R6: An EOI to a source in state 2'b11 presents one event for that source. The state stays 2'b11 until that event is accepted, then becomes 2'b10.
- R7: A source in state 2'b01 ignores triggers: no event is presented and its state stays 2'b01.
- R8: A masked source in state 2'b00 discards triggers. No event is presented, the state stays 2'b00, and clearing the mask afterwards brings no late event.
- R9: An LSI source does not move from 2'b10 to 2'b11 while its line stays high. If the line is still high after the EOI that returns it to 2'b00, a fresh event is presented.
- R10: While evt_valid_o is high and evt_ready_i low, the presented event and the source's state stay unchanged.
- R11: When several sources request in the same cycle, the lowest index is presented first, and the next one follows after acceptance.
- R12: A configuration write stores state, mask, CPU, priority and data for the selected source. A read returns them along with the source type (1 = LSI).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trig_i | input | NSRC | Per-source trigger (pulse for MSI, level for LSI) |
| eoi_valid_i | input | 1 | End-of-interrupt strobe |
| eoi_idx_i | input | IDX_W | Source addressed by the EOI |
| evt_valid_o | output | 1 | Event presented |
| evt_ready_i | input | 1 | Event consumer ready |
| evt_src_o | output | IDX_W | Index of the presented source |
| evt_cpu_o | output | CPU_W | Target CPU of the event |
| evt_prio_o | output | PRIO_W | Priority of the event |
| evt_data_o | output | DATA_W | Event data word |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | IDX_W | Source selected for read and write |
| cfg_pq_i | input | 2 | State to write |
| cfg_mask_i | input | 1 | Mask to write |
| cfg_cpu_i | input | CPU_W | CPU to write |
| cfg_prio_i | input | PRIO_W | Priority to write |
| cfg_data_i | input | DATA_W | Data word to write |
| cfg_pq_o | output | 2 | State of selected source |
| cfg_mask_o | output | 1 | Mask of selected source |
| cfg_lsi_o | output | 1 | Type of selected source, 1 = LSI |
| cfg_cpu_o | output | CPU_W | CPU of selected source |
| cfg_prio_o | output | PRIO_W | Priority of selected source |
| cfg_data_o | output | DATA_W | Data word of selected source |

## Verification
A wrong state in a source shows up at the ports in one of two ways. A spurious or missing event appears on the valid/ready port in the cycle after the trigger or EOI is registered. Otherwise the next read of the configuration port shows the wrong state. A lost coalesced event stays hidden until the EOI and shows as an absent re-emission in the following cycle. A premature state change during a stall shows at once as a state readback that differs from the pre-acceptance value.

// File: rtl/pq_src_pkg.sv
package pq_src_pkg;
  typedef enum logic [1:0] {
    PQ_READY  = 2'b00,
    PQ_OFF    = 2'b01,
    PQ_PEND   = 2'b10,
    PQ_QUEUED = 2'b11
  } pq_e;
endpackage

// File: rtl/pq_src_cell.sv
module pq_src_cell
  import pq_src_pkg::*;
#(
  parameter bit IS_LSI = 1'b0,
  parameter int CPU_W  = 4,
  parameter int PRIO_W = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic              eoi_i,
  input  logic              accept_i,
  input  logic              wr_i,
  input  logic [1:0]        wr_pq_i,
  input  logic              wr_mask_i,
  input  logic [CPU_W-1:0]  wr_cpu_i,
  input  logic [PRIO_W-1:0] wr_prio_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              req_o,
  output logic [1:0]        pq_o,
  output logic              mask_o,
  output logic [CPU_W-1:0]  cpu_o,
  output logic [PRIO_W-1:0] prio_o,
  output logic [DATA_W-1:0] data_o
);
  pq_e  pq_q, pq_n;
  logic mask_q, mask_n;
  logic hit_q, hit_n;
  logic reemit_q, reemit_n;
  logic consume;
  logic [CPU_W-1:0]  cpu_q;
  logic [PRIO_W-1:0] prio_q;
  logic [DATA_W-1:0] data_q;

  always_comb begin
    pq_n     = pq_q;
    mask_n   = mask_q;
    reemit_n = reemit_q;
    consume  = 1'b0;
    if (wr_i) begin
      pq_n     = pq_e'(wr_pq_i);
      mask_n   = wr_mask_i;
      reemit_n = 1'b0;
      consume  = 1'b1;
    end else begin
      unique case (pq_q)
        PQ_OFF: consume = 1'b1;
        PQ_READY: begin
          if (accept_i) begin
            pq_n    = PQ_PEND;
            consume = 1'b1;
          end else if (mask_q) begin
            consume = 1'b1;
          end
        end
        PQ_PEND: begin
          if (eoi_i) begin
            pq_n = PQ_READY;
          end else if (hit_q && !IS_LSI) begin
            pq_n    = PQ_QUEUED;
            consume = 1'b1;
          end
        end
        PQ_QUEUED: begin
          consume = 1'b1;
          if (accept_i) begin
            pq_n     = PQ_PEND;
            reemit_n = 1'b0;
          end else if (eoi_i) begin
            reemit_n = 1'b1;
          end
        end
        default: pq_n = pq_q;
      endcase
    end
    if (IS_LSI) hit_n = trig_i;
    else        hit_n = (hit_q & ~consume) | trig_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pq_q     <= PQ_OFF;
      mask_q   <= 1'b1;
      hit_q    <= 1'b0;
      reemit_q <= 1'b0;
    end else begin
      pq_q     <= pq_n;
      mask_q   <= mask_n;
      hit_q    <= hit_n;
      reemit_q <= reemit_n;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_q  <= '0;
      prio_q <= '0;
      data_q <= '0;
    end else if (wr_i) begin
      cpu_q  <= wr_cpu_i;
      prio_q <= wr_prio_i;
      data_q <= wr_data_i;
    end
  end

  assign req_o  = !mask_q && (((pq_q == PQ_READY) && hit_q) ||
                              ((pq_q == PQ_QUEUED) && reemit_q));
  assign pq_o   = pq_q;
  assign mask_o = mask_q;
  assign cpu_o  = cpu_q;
  assign prio_o = prio_q;
  assign data_o = data_q;
endmodule

// File: rtl/pq_src_arb.sv
module pq_src_arb #(
  parameter int NSRC  = 8,
  parameter int IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]  req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/pq_src_bank.sv
module pq_src_bank #(
  parameter int              NSRC    = 8,
  parameter int              CPU_W   = 4,
  parameter int              PRIO_W  = 3,
  parameter int              DATA_W  = 16,
  parameter logic [NSRC-1:0] LSI_MAP = 8'hC0,
  localparam int             IDX_W   = $clog2(NSRC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   trig_i,
  input  logic              eoi_valid_i,
  input  logic [IDX_W-1:0]  eoi_idx_i,
  output logic              evt_valid_o,
  input  logic              evt_ready_i,
  output logic [IDX_W-1:0]  evt_src_o,
  output logic [CPU_W-1:0]  evt_cpu_o,
  output logic [PRIO_W-1:0] evt_prio_o,
  output logic [DATA_W-1:0] evt_data_o,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [1:0]        cfg_pq_i,
  input  logic              cfg_mask_i,
  input  logic [CPU_W-1:0]  cfg_cpu_i,
  input  logic [PRIO_W-1:0] cfg_prio_i,
  input  logic [DATA_W-1:0] cfg_data_i,
  output logic [1:0]        cfg_pq_o,
  output logic              cfg_mask_o,
  output logic              cfg_lsi_o,
  output logic [CPU_W-1:0]  cfg_cpu_o,
  output logic [PRIO_W-1:0] cfg_prio_o,
  output logic [DATA_W-1:0] cfg_data_o
);
  logic                          rst_meta_q, rst_sync_q;
  logic [NSRC-1:0]               req_vec, mask_vec;
  logic [NSRC-1:0][1:0]          pq_vec;
  logic [NSRC-1:0][CPU_W-1:0]    cpu_vec;
  logic [NSRC-1:0][PRIO_W-1:0]   prio_vec;
  logic [NSRC-1:0][DATA_W-1:0]   data_vec;
  logic                          arb_any;
  logic [IDX_W-1:0]              arb_idx, cur_idx;
  logic                          lock_vld_q, lock_vld_n;
  logic [IDX_W-1:0]              lock_idx_q, lock_idx_n;
  logic                          accept;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    pq_src_cell #(
      .IS_LSI (LSI_MAP[g]),
      .CPU_W  (CPU_W),
      .PRIO_W (PRIO_W),
      .DATA_W (DATA_W)
    ) u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_sync_q),
      .trig_i    (trig_i[g]),
      .eoi_i     (eoi_valid_i && (eoi_idx_i == IDX_W'(g))),
      .accept_i  (accept && (cur_idx == IDX_W'(g))),
      .wr_i      (cfg_we_i && (cfg_idx_i == IDX_W'(g))),
      .wr_pq_i   (cfg_pq_i),
      .wr_mask_i (cfg_mask_i),
      .wr_cpu_i  (cfg_cpu_i),
      .wr_prio_i (cfg_prio_i),
      .wr_data_i (cfg_data_i),
      .req_o     (req_vec[g]),
      .pq_o      (pq_vec[g]),
      .mask_o    (mask_vec[g]),
      .cpu_o     (cpu_vec[g]),
      .prio_o    (prio_vec[g]),
      .data_o    (data_vec[g])
    );
  end

  pq_src_arb #(.NSRC(NSRC), .IDX_W(IDX_W)) u_arb (
    .req_i (req_vec),
    .any_o (arb_any),
    .idx_o (arb_idx)
  );

  assign cur_idx     = lock_vld_q ? lock_idx_q : arb_idx;
  assign evt_valid_o = lock_vld_q || arb_any;
  assign accept      = evt_valid_o && evt_ready_i;

  always_comb begin
    lock_vld_n = evt_valid_o && !evt_ready_i;
    lock_idx_n = lock_idx_q;
    if (lock_vld_n) lock_idx_n = cur_idx;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_vld_q <= 1'b0;
      lock_idx_q <= '0;
    end else if (!rst_sync_q) begin
      lock_vld_q <= 1'b0;
      lock_idx_q <= '0;
    end else begin
      lock_vld_q <= lock_vld_n;
      lock_idx_q <= lock_idx_n;
    end
  end

  assign evt_src_o  = cur_idx;
  assign evt_cpu_o  = cpu_vec[cur_idx];
  assign evt_prio_o = prio_vec[cur_idx];
  assign evt_data_o = data_vec[cur_idx];

  assign cfg_pq_o   = pq_vec[cfg_idx_i];
  assign cfg_mask_o = mask_vec[cfg_idx_i];
  assign cfg_lsi_o  = LSI_MAP[cfg_idx_i];
  assign cfg_cpu_o  = cpu_vec[cfg_idx_i];
  assign cfg_prio_o = prio_vec[cfg_idx_i];
  assign cfg_data_o = data_vec[cfg_idx_i];
endmodule

// File: rtl/pq_src_bank_chk.sv
module pq_src_bank_chk #(
  parameter int NSRC  = 8,
  parameter int IDX_W = 3
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 evt_valid_o,
  input logic                 evt_ready_i,
  input logic [IDX_W-1:0]     evt_src_o,
  input logic                 cfg_we_i,
  input logic [IDX_W-1:0]     cfg_idx_i,
  input logic                 lock_vld_q,
  input logic [NSRC-1:0][1:0] pq_vec,
  input logic [NSRC-1:0]      mask_vec
);
  logic wr_hits_src;
  assign wr_hits_src = cfg_we_i && (cfg_idx_i == evt_src_o);

  AST_STALL_HOLDS_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && !evt_ready_i) |=> (evt_valid_o && $stable(evt_src_o))); // R10

  AST_STALL_HOLDS_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && !evt_ready_i && !wr_hits_src)
      |=> (pq_vec[$past(evt_src_o)] == $past(pq_vec[evt_src_o]))); // R10

  AST_ACCEPT_TO_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && evt_ready_i && !wr_hits_src)
      |=> (pq_vec[$past(evt_src_o)] == 2'b10)); // R2

  AST_OFF_NEVER_GRANTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && !lock_vld_q) |-> (pq_vec[evt_src_o] != 2'b01)); // R7

  AST_MASKED_NEVER_GRANTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_o && !lock_vld_q) |-> !mask_vec[evt_src_o]); // R8
endmodule

bind pq_src_bank pq_src_bank_chk #(.NSRC(NSRC), .IDX_W(IDX_W)) u_pq_src_bank_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .evt_valid_o (evt_valid_o),
  .evt_ready_i (evt_ready_i),
  .evt_src_o   (evt_src_o),
  .cfg_we_i    (cfg_we_i),
  .cfg_idx_i   (cfg_idx_i),
  .lock_vld_q  (lock_vld_q),
  .pq_vec      (pq_vec),
  .mask_vec    (mask_vec)
);

// File: tb/pq_src_bank_bench.sv
`timescale 1ns/1ps
module pq_src_bank_bench;
  localparam int NSRC = 8, CPU_W = 4, PRIO_W = 3, DATA_W = 16, IDX_W = 3;
  localparam logic [NSRC-1:0] LSI_MAP = 8'hC0;

  logic clk = 1'b0;
  logic rst_n;
  logic [NSRC-1:0] trig;
  logic eoi_vld;
  logic [IDX_W-1:0] eoi_idx;
  logic evt_valid, evt_ready;
  logic [IDX_W-1:0] evt_src;
  logic [CPU_W-1:0] evt_cpu;
  logic [PRIO_W-1:0] evt_prio;
  logic [DATA_W-1:0] evt_data;
  logic cfg_we;
  logic [IDX_W-1:0] cfg_idx;
  logic [1:0] cfg_pq_w, cfg_pq_r;
  logic cfg_mask_w, cfg_mask_r, cfg_lsi_r;
  logic [CPU_W-1:0] cfg_cpu_w, cfg_cpu_r;
  logic [PRIO_W-1:0] cfg_prio_w, cfg_prio_r;
  logic [DATA_W-1:0] cfg_data_w, cfg_data_r;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  logic [1:0]        m_pq   [NSRC];
  logic              m_mask [NSRC];
  logic [CPU_W-1:0]  m_cpu  [NSRC];
  logic [PRIO_W-1:0] m_prio [NSRC];
  logic [DATA_W-1:0] m_data [NSRC];

  always #5 clk = ~clk;

  pq_src_bank #(.NSRC(NSRC), .CPU_W(CPU_W), .PRIO_W(PRIO_W), .DATA_W(DATA_W),
                .LSI_MAP(LSI_MAP)) u_pq_src_bank (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig),
    .eoi_valid_i(eoi_vld), .eoi_idx_i(eoi_idx),
    .evt_valid_o(evt_valid), .evt_ready_i(evt_ready), .evt_src_o(evt_src),
    .evt_cpu_o(evt_cpu), .evt_prio_o(evt_prio), .evt_data_o(evt_data),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_pq_i(cfg_pq_w),
    .cfg_mask_i(cfg_mask_w), .cfg_cpu_i(cfg_cpu_w), .cfg_prio_i(cfg_prio_w),
    .cfg_data_i(cfg_data_w), .cfg_pq_o(cfg_pq_r), .cfg_mask_o(cfg_mask_r),
    .cfg_lsi_o(cfg_lsi_r), .cfg_cpu_o(cfg_cpu_r), .cfg_prio_o(cfg_prio_r),
    .cfg_data_o(cfg_data_r));

  function automatic logic [31:0] exp_route(input int idx);
    return {5'd0, m_cpu[idx], m_prio[idx], 4'd0, m_data[idx]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input int idx, input logic [1:0] pq, input logic msk,
                    input logic [CPU_W-1:0] c, input logic [PRIO_W-1:0] p,
                    input logic [DATA_W-1:0] d);
    cfg_we = 1'b1; cfg_idx = IDX_W'(idx); cfg_pq_w = pq; cfg_mask_w = msk;
    cfg_cpu_w = c; cfg_prio_w = p; cfg_data_w = d;
    m_pq[idx] = pq; m_mask[idx] = msk; m_cpu[idx] = c; m_prio[idx] = p; m_data[idx] = d;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic rd_pq(input string req, input int idx, input logic [1:0] exp);
    cfg_idx = IDX_W'(idx);
    #1;
    chk(req, 32'(cfg_pq_r), 32'(exp));
  endtask

  task automatic pulse(input int idx);
    trig[idx] = 1'b1;
    tick();
    trig[idx] = 1'b0;
  endtask

  task automatic eoi(input int idx);
    eoi_vld = 1'b1; eoi_idx = IDX_W'(idx);
    tick();
    eoi_vld = 1'b0;
  endtask

  task automatic chk_evt(input string req, input int idx);
    chk(req, 32'(evt_valid), 32'd1);
    chk(req, 32'(evt_src), 32'(idx));
    chk(req, {5'd0, evt_cpu, evt_prio, 4'd0, evt_data}, exp_route(idx));
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; trig = '0; eoi_vld = 1'b0; eoi_idx = '0; evt_ready = 1'b1;
    cfg_we = 1'b0; cfg_idx = '0; cfg_pq_w = '0; cfg_mask_w = 1'b0;
    cfg_cpu_w = '0; cfg_prio_w = '0; cfg_data_w = '0;
    for (int i = 0; i < NSRC; i++) begin
      m_pq[i] = 2'b01; m_mask[i] = 1'b1; m_cpu[i] = '0; m_prio[i] = '0; m_data[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) tick();

    // R1 reset state
    chk("R1 valid", 32'(evt_valid), 32'd0);
    for (int i = 0; i < NSRC; i++) begin
      cfg_idx = IDX_W'(i);
      #1;
      chk("R1 pq", 32'(cfg_pq_r), 32'd1);
      chk("R1 mask", 32'(cfg_mask_r), 32'd1);
      chk("R1 route", {5'd0, cfg_cpu_r, cfg_prio_r, 4'd0, cfg_data_r}, 32'd0);
      chk("R12 type", 32'(cfg_lsi_r), 32'(LSI_MAP[i]));
    end

    // R2 + R10: emit from ready, stalled two cycles
    wr(0, 2'b00, 1'b0, 4'd3, 3'd5, 16'h1234);
    evt_ready = 1'b0;
    pulse(0);
    chk_evt("R2 event", 0);
    rd_pq("R10 pq held", 0, 2'b00);
    tick();
    chk_evt("R10 stall hold", 0);
    rd_pq("R10 pq held", 0, 2'b00);
    evt_ready = 1'b1;
    tick();
    chk("R2 single event", 32'(evt_valid), 32'd0);
    rd_pq("R2 pq pending", 0, 2'b10);

    // R3 coalesce into queued
    pulse(0);
    chk("R3 no event", 32'(evt_valid), 32'd0);
    tick();
    rd_pq("R3 pq queued", 0, 2'b11);
    chk("R3 no event", 32'(evt_valid), 32'd0);

    // R4 stays queued
    pulse(0);
    tick();
    rd_pq("R4 pq queued", 0, 2'b11);
    chk("R4 no event", 32'(evt_valid), 32'd0);

    // R6 EOI from queued re-emits
    evt_ready = 1'b0;
    eoi(0);
    chk_evt("R6 re-emit", 0);
    rd_pq("R6 pq until accept", 0, 2'b11);
    evt_ready = 1'b1;
    tick();
    rd_pq("R6 pq pending", 0, 2'b10);
    chk("R6 one event", 32'(evt_valid), 32'd0);

    // R5 EOI from pending returns to ready
    eoi(0);
    chk("R5 no event", 32'(evt_valid), 32'd0);
    rd_pq("R5 pq ready", 0, 2'b00);
    tick();
    chk("R5 no event", 32'(evt_valid), 32'd0);

    // R7 off source ignores trigger
    wr(1, 2'b01, 1'b0, 4'd7, 3'd1, 16'h00AA);
    pulse(1);
    chk("R7 no event", 32'(evt_valid), 32'd0);
    tick();
    rd_pq("R7 pq off", 1, 2'b01);
    chk("R7 no event", 32'(evt_valid), 32'd0);

    // R8 masked source drops trigger
    wr(2, 2'b00, 1'b1, 4'd2, 3'd2, 16'h0BB0);
    pulse(2);
    chk("R8 no event", 32'(evt_valid), 32'd0);
    tick();
    rd_pq("R8 pq ready", 2, 2'b00);
    wr(2, 2'b00, 1'b0, 4'd2, 3'd2, 16'h0BB0);
    chk("R8 no late event", 32'(evt_valid), 32'd0);
    tick();
    chk("R8 no late event", 32'(evt_valid), 32'd0);

    // R11 priority between simultaneous requests
    wr(3, 2'b00, 1'b0, 4'd1, 3'd6, 16'h3333);
    wr(4, 2'b00, 1'b0, 4'd9, 3'd4, 16'h4444);
    evt_ready = 1'b0;
    trig[3] = 1'b1; trig[4] = 1'b1;
    tick();
    trig[3] = 1'b0; trig[4] = 1'b0;
    chk_evt("R11 lowest first", 3);
    evt_ready = 1'b1;
    tick();
    chk_evt("R11 next source", 4);
    tick();
    chk("R11 drained", 32'(evt_valid), 32'd0);
    rd_pq("R11 pq3", 3, 2'b10);
    rd_pq("R11 pq4", 4, 2'b10);

    // R9 LSI level behaviour
    wr(6, 2'b00, 1'b0, 4'd5, 3'd7, 16'h6666);
    trig[6] = 1'b1;
    tick();
    chk_evt("R9 lsi event", 6);
    tick();
    rd_pq("R9 pq pending", 6, 2'b10);
    repeat (3) tick();
    rd_pq("R9 no queued", 6, 2'b10);
    chk("R9 no event", 32'(evt_valid), 32'd0);
    eoi(6);
    chk_evt("R9 retrigger", 6);
    tick();
    rd_pq("R9 pq pending", 6, 2'b10);
    trig[6] = 1'b0;
    tick();
    eoi(6);
    chk("R9 line low", 32'(evt_valid), 32'd0);
    rd_pq("R9 pq ready", 6, 2'b00);

    // R12 random config writes and readback
    for (int k = 0; k < 40; k++) begin
      int idx;
      idx = int'($urandom_range(NSRC - 1, 0));
      wr(idx, (($urandom_range(1, 0) == 1) ? 2'b01 : 2'b10), 1'($urandom),
         CPU_W'($urandom), PRIO_W'($urandom), DATA_W'($urandom));
    end
    for (int i = 0; i < NSRC; i++) begin
      cfg_idx = IDX_W'(i);
      #1;
      chk("R12 pq", 32'(cfg_pq_r), 32'(m_pq[i]));
      chk("R12 mask", 32'(cfg_mask_r), 32'(m_mask[i]));
      chk("R12 route", {5'd0, cfg_cpu_r, cfg_prio_r, 4'd0, cfg_data_r}, exp_route(i));
    end
    chk("R12 no event", 32'(evt_valid), 32'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule